// File: doc/BRIEF.md
# Programmable Timing State Sequencer

The sequencer walks through a table of 16-bit state words and presents the control fields of the active word on registered outputs. These outputs drive an analog measurement front end: DAC enable, comparator enable, excitation/sample, LC enable, output latch enable, autozero/clock-on, test-set select and a 2-bit channel select. The channel select is also decoded into a one-hot channel enable and a per-channel undamp vector. Each state sets its own duration as a repeat count. It also picks whether that count advances on a fast tick strobe or a slow tick strobe. Both strobes are enables in the single clock domain.

Software loads the table through a small register bus while the sequencer is idle. Entry 0 is the idle entry, and its controls appear on the outputs whenever no sequence runs. A start pulse launches a run at entry 1. The run continues until an entry flagged as stop has taken one fast tick. The sequencer then returns to entry 0 and pulses done. If no stop entry is found before the end of the table, the run is abandoned with an error pulse. During a run the table is locked against the bus.

Top module: `tseq_top`

## Requirements
- R1: State word layout: bits 15:11 repeat count, bit 10 time-base select, bit 9 stop flag, bit 8 DAC, bit 7 test select, bit 6 latch enable, bit 5 autozero/clock-on, bit 4 comparator, bit 3 excitation, bit 2 LC enable, bits 1:0 channel. Each control output equals the corresponding bit of the active entry.
- R2: A non-stop state lasts repeat+1 ticks of its selected time base, counted from the cycle after it is entered.
- R3: Time-base select 0 counts fast_tick_i strobes and 1 counts slow_tick_i strobes; strobes of the other base have no effect on the state's duration.
- R4: A stop state lasts exactly one fast tick, regardless of its repeat and time-base fields. The sequencer then goes to entry 0, drops busy_o and raises done_o for exactly one cycle.
- R5: A start_i pulse while idle sets busy_o and enters entry 1 at the next clock. A start_i pulse while busy_o is high has no effect.
- R6: While idle, a bus write stores bus_wdata_i at bus_addr_i, and bus_rdata_o returns the addressed entry combinationally. While busy_o is high, writes are discarded and bus_rdata_o reads 0x0000.
- R7: ch_en_o is one-hot with bit n set for channel value n. undamp_o equals ch_en_o when LC enable is set, and is all zero otherwise.
- R8: tset_o is one-hot: bit 0 when test select is 0, and bit 1 when it is 1.
- R9: Control outputs are registered and change during a run only when the entry index changes. While idle they reflect entry 0, including a new write to entry 0 one cycle after it.
- R10: If the last entry (index DEPTH-1) ends without a stop flag, the sequencer returns to entry 0 and drops busy_o, and err_o pulses for one cycle with done_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fast_tick_i | input | 1 | Fast time-base strobe |
| slow_tick_i | input | 1 | Slow time-base strobe |
| start_i | input | 1 | Sequence start pulse |
| bus_we_i | input | 1 | Table write strobe |
| bus_addr_i | input | AW | Table entry address |
| bus_wdata_i | input | 16 | Table write data |
| bus_rdata_o | output | 16 | Table read data, zero while busy |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle pulse at the end of a stopped sequence |
| err_o | output | 1 | One-cycle pulse when the table ran out without a stop |
| idx_o | output | AW | Active entry index |
| dac_o | output | 1 | DAC enable |
| comp_o | output | 1 | Comparator enable |
| exc_o | output | 1 | Excitation / sample enable |
| lc_o | output | 1 | LC enable |
| latch_o | output | 1 | Output latch enable |
| az_o | output | 1 | Autozero / clock-on |
| tsel_o | output | 1 | Test select bit |
| ch_sel_o | output | 2 | Channel select |
| ch_en_o | output | 4 | One-hot channel enable |
| undamp_o | output | 4 | Per-channel undamp |
| tset_o | output | 2 | One-hot active test set |

## Verification
The bench builds the block with the default 32-entry table and the 5-bit repeat field. At this depth a table with no stop entry runs through 31 one-cycle states before it wraps, so the error path can be reached. The largest repeat value, 31, can be placed on a stop entry to show that the stop entry still lasts a single fast tick. The slow time base is driven by hand-placed strobes, so a count of slow ticks can be checked without waiting through a long divider.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
  localparam int WORD_W = 16;
  localparam int REP_W  = 5;
  localparam int CH_W   = 2;
  localparam int NCH    = 1 << CH_W;

  typedef struct packed {
    logic [REP_W-1:0] rep;
    logic             slow_sel;
    logic             stop;
  } hdr_t;

  typedef struct packed {
    logic            dac;
    logic            tsel;
    logic            latch;
    logic            az;
    logic            comp;
    logic            exc;
    logic            lc;
    logic [CH_W-1:0] ch;
  } ctl_t;

  typedef struct packed {
    hdr_t hdr;
    ctl_t ctl;
  } word_t;
endpackage

// File: rtl/tseq_table.sv
module tseq_table
  import tseq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic [AW-1:0]     cur_idx_i,
  output hdr_t              cur_hdr_o,
  input  logic [AW-1:0]     nxt_idx_i,
  output ctl_t              nxt_ctl_o
);
  word_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i && !lock_i) begin
      mem_q[addr_i] <= word_t'(wdata_i);
    end
  end

  assign rdata_o   = lock_i ? '0 : WORD_W'(mem_q[addr_i]);
  assign cur_hdr_o = mem_q[cur_idx_i].hdr;
  assign nxt_ctl_o = mem_q[nxt_idx_i].ctl;
endmodule

// File: rtl/tseq_ctrl.sv
module tseq_ctrl
  import tseq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          fast_i,
  input  logic          slow_i,
  input  hdr_t          hdr_i,
  output logic [AW-1:0] idx_o,
  output logic [AW-1:0] idx_nxt_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [AW-1:0]    idx_q, idx_d;
  logic [REP_W-1:0] cnt_q, lim;
  logic             busy_q, done_q, err_q;
  logic             tick, go, fin, at_end;

  // stop entries always run on one fast tick
  always_comb begin
    tick   = hdr_i.stop ? fast_i : (hdr_i.slow_sel ? slow_i : fast_i);
    lim    = hdr_i.stop ? '0 : hdr_i.rep;
    go     = !busy_q && start_i;
    fin    = busy_q && tick && (cnt_q == lim);
    at_end = (idx_q == LAST_IDX);
    idx_d  = idx_q;
    if (go)                          idx_d = AW'(1);
    else if (fin && (hdr_i.stop || at_end)) idx_d = '0;
    else if (fin)                    idx_d = idx_q + AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      idx_q  <= idx_d;
      done_q <= fin && hdr_i.stop;
      err_q  <= fin && !hdr_i.stop && at_end;
      if (go)                     busy_q <= 1'b1;
      else if (fin && (hdr_i.stop || at_end)) busy_q <= 1'b0;
      if (go || fin)              cnt_q <= '0;
      else if (busy_q && tick)    cnt_q <= cnt_q + REP_W'(1);
    end
  end

  assign idx_o     = idx_q;
  assign idx_nxt_o = idx_d;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/tseq_decode.sv
module tseq_decode
  import tseq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  ctl_t            ctl_i,
  output ctl_t            ctl_o,
  output logic [NCH-1:0]  ch_en_o,
  output logic [NCH-1:0]  undamp_o,
  output logic [1:0]      tset_o
);
  ctl_t           ctl_q;
  logic [NCH-1:0] en_d, en_q, ud_q;
  logic [1:0]     ts_q;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign en_d[c] = (ctl_i.ch == CH_W'(c));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
      en_q  <= NCH'(1);
      ud_q  <= '0;
      ts_q  <= 2'b01;
    end else begin
      ctl_q <= ctl_i;
      en_q  <= en_d;
      ud_q  <= en_d & {NCH{ctl_i.lc}};
      ts_q  <= {ctl_i.tsel, !ctl_i.tsel};
    end
  end

  assign ctl_o    = ctl_q;
  assign ch_en_o  = en_q;
  assign undamp_o = ud_q;
  assign tset_o   = ts_q;
endmodule

// File: rtl/tseq_top.sv
module tseq_top
  import tseq_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fast_tick_i,
  input  logic              slow_tick_i,
  input  logic              start_i,
  input  logic              bus_we_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [WORD_W-1:0] bus_wdata_i,
  output logic [WORD_W-1:0] bus_rdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [AW-1:0]     idx_o,
  output logic              dac_o,
  output logic              comp_o,
  output logic              exc_o,
  output logic              lc_o,
  output logic              latch_o,
  output logic              az_o,
  output logic              tsel_o,
  output logic [CH_W-1:0]   ch_sel_o,
  output logic [NCH-1:0]    ch_en_o,
  output logic [NCH-1:0]    undamp_o,
  output logic [1:0]        tset_o
);
  logic [AW-1:0] idx, idx_nxt;
  logic          busy;
  hdr_t          cur_hdr;
  ctl_t          nxt_ctl, ctl;

  tseq_table #(.DEPTH(DEPTH)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_i    (busy),
    .we_i      (bus_we_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .rdata_o   (bus_rdata_o),
    .cur_idx_i (idx),
    .cur_hdr_o (cur_hdr),
    .nxt_idx_i (idx_nxt),
    .nxt_ctl_o (nxt_ctl)
  );

  tseq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .fast_i    (fast_tick_i),
    .slow_i    (slow_tick_i),
    .hdr_i     (cur_hdr),
    .idx_o     (idx),
    .idx_nxt_o (idx_nxt),
    .busy_o    (busy),
    .done_o    (done_o),
    .err_o     (err_o)
  );

  tseq_decode u_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ctl_i    (nxt_ctl),
    .ctl_o    (ctl),
    .ch_en_o  (ch_en_o),
    .undamp_o (undamp_o),
    .tset_o   (tset_o)
  );

  assign busy_o   = busy;
  assign idx_o    = idx;
  assign dac_o    = ctl.dac;
  assign comp_o   = ctl.comp;
  assign exc_o    = ctl.exc;
  assign lc_o     = ctl.lc;
  assign latch_o  = ctl.latch;
  assign az_o     = ctl.az;
  assign tsel_o   = ctl.tsel;
  assign ch_sel_o = ctl.ch;
endmodule

// File: rtl/tseq_chk.sv
module tseq_chk #(
  parameter int AW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [15:0]   bus_rdata_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic [AW-1:0] idx_o,
  input logic          lc_o,
  input logic [8:0]    ctl_vec,
  input logic [3:0]    ch_en_o,
  input logic [3:0]    undamp_o,
  input logic [1:0]    tset_o
);
  // R4
  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R4
  a_r4_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && idx_o == '0));
  // R5
  a_r5_start_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && idx_o == AW'(1)));
  // R6
  a_r6_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (bus_rdata_o == '0));
  // R7
  a_r7_undamp_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((undamp_o & ~ch_en_o) == '0) && (lc_o || undamp_o == '0) && $onehot(ch_en_o));
  // R8
  a_r8_tset_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(tset_o));
  // R9
  a_r9_hold_in_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && idx_o == $past(idx_o)) |-> $stable(ctl_vec));
  // R10
  a_r10_err_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!done_o && !busy_o && idx_o == '0));
endmodule

bind tseq_top tseq_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .bus_rdata_o (bus_rdata_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .idx_o       (idx_o),
  .lc_o        (lc_o),
  .ctl_vec     ({dac_o, tsel_o, latch_o, az_o, comp_o, exc_o, lc_o, ch_sel_o}),
  .ch_en_o     (ch_en_o),
  .undamp_o    (undamp_o),
  .tset_o      (tset_o)
);

// File: tb/sim_tseq_top.sv
module sim_tseq_top;
  localparam int DEPTH = 32;
  localparam int AW = $clog2(DEPTH);

  logic clk = 1'b0, rst_n = 1'b0;
  logic fast = 1'b0, slow = 1'b0, start = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0, rdata;
  logic busy, done, err, dac, comp, exc, lc, latch, az, tsel;
  logic [AW-1:0] idx;
  logic [1:0] ch_sel, tset;
  logic [3:0] ch_en, undamp;
  int vectors = 0, miscompares = 0;

  always #5 clk = ~clk;

  tseq_top #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fast_tick_i(fast), .slow_tick_i(slow),
    .start_i(start), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .busy_o(busy), .done_o(done), .err_o(err),
    .idx_o(idx), .dac_o(dac), .comp_o(comp), .exc_o(exc), .lc_o(lc),
    .latch_o(latch), .az_o(az), .tsel_o(tsel), .ch_sel_o(ch_sel),
    .ch_en_o(ch_en), .undamp_o(undamp), .tset_o(tset)
  );

  // R1 layout: rep[15:11] slow[10] stop[9] dac[8] tsel[7] latch[6] az[5] comp[4] exc[3] lc[2] ch[1:0]
  function automatic logic [15:0] mk(input int rep, input bit sl, input bit st,
      input bit d, input bit ts, input bit la, input bit a, input bit cm,
      input bit ex, input bit l, input int c);
    return {rep[4:0], sl, st, d, ts, la, a, cm, ex, l, c[1:0]};
  endfunction

  function automatic logic [8:0] ctlv();
    return {dac, tsel, latch, az, comp, exc, lc, ch_sel};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk); we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int a, input logic [15:0] exp);
    addr = AW'(a); #1;
    chk(req, rdata, exp);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic t_reset();
    chk("R4 reset busy", busy, 0);
    chk("R4 reset done", done, 0);
    chk("R10 reset err", err, 0);
    chk("R9 reset idx", idx, 0);
    chk("R9 reset ctl", ctlv(), 0);
    chk("R7 reset ch_en", ch_en, 4'b0001);
    chk("R8 reset tset", tset, 2'b01);
    rd_chk("R6 reset read", 0, 16'h0000);
  endtask

  task automatic t_bus_idle();
    wr(0, mk(0,0,0, 1,0,0,1,0,0,0, 2));
    rd_chk("R6 readback entry0", 0, mk(0,0,0, 1,0,0,1,0,0,0, 2));
    @(negedge clk);
    chk("R9 idle reflects entry0", ctlv(), 9'b1_0_0_1_0_0_0_10);
    chk("R7 idle ch_en", ch_en, 4'b0100);
    chk("R7 idle undamp off", undamp, 4'b0000);
  endtask

  task automatic t_fast_seq();
    logic [15:0] e1 = mk(2,0,0, 0,0,0,0,0,1,1, 1);
    wr(1, e1);
    wr(2, mk(0,0,0, 0,1,0,0,1,0,0, 3));
    wr(3, mk(31,1,1, 0,0,0,0,0,0,0, 0));
    rd_chk("R6 readback entry1", 1, e1);
    fast = 1'b1; slow = 1'b0;
    pulse_start();                      // after edge e1
    chk("R5 start enters entry1", idx, 1);
    chk("R5 busy set", busy, 1);
    chk("R1 entry1 controls", ctlv(), 9'b0_0_0_0_0_1_1_01);
    chk("R7 entry1 undamp", undamp, 4'b0010);
    rd_chk("R6 read while busy", 1, 16'h0000);
    we = 1'b1; wdata = 16'hffff;
    @(negedge clk);                     // e2
    we = 1'b0; start = 1'b1;
    chk("R2 entry1 cycle2", idx, 1);
    @(negedge clk);                     // e3
    start = 1'b0;
    chk("R5 start ignored while busy", idx, 1);
    chk("R9 controls held", ctlv(), 9'b0_0_0_0_0_1_1_01);
    @(negedge clk);                     // e4
    chk("R2 entry1 lasted 3 fast ticks", idx, 2);
    chk("R1 entry2 comparator", comp, 1);
    chk("R8 entry2 tset", tset, 2'b10);
    chk("R7 entry2 ch_en", ch_en, 4'b1000);
    chk("R7 entry2 undamp off", undamp, 4'b0000);
    @(negedge clk);                     // e5
    chk("R2 entry2 one tick", idx, 3);
    @(negedge clk);                     // e6
    chk("R4 stop one fast tick", {busy, done, idx}, {1'b0, 1'b1, AW'(0)});
    chk("R9 back to entry0 ctl", ctlv(), 9'b1_0_0_1_0_0_0_10);
    @(negedge clk);
    chk("R4 done single cycle", done, 0);
    rd_chk("R6 busy write discarded", 1, e1);
  endtask

  task automatic t_slow_seq();
    wr(1, mk(1,1,0, 1,0,0,0,0,0,0, 0));
    wr(2, mk(5,1,1, 0,0,1,0,0,0,0, 0));
    fast = 1'b1; slow = 1'b0;
    pulse_start();
    chk("R5 slow start", idx, 1);
    for (int i = 0; i < 4; i++) @(negedge clk);
    chk("R3 fast ticks ignored by slow state", idx, 1);
    fast = 1'b0;
    slow = 1'b1; @(negedge clk); slow = 1'b0;
    chk("R2 one slow tick of two", idx, 1);
    @(negedge clk);
    slow = 1'b1; @(negedge clk); slow = 1'b0;
    chk("R3 second slow tick advances", idx, 2);
    chk("R1 stop entry latch", latch, 1);
    slow = 1'b1; @(negedge clk); slow = 1'b0;
    @(negedge clk);
    chk("R4 stop ignores slow ticks", {busy, idx}, {1'b1, AW'(2)});
    fast = 1'b1; @(negedge clk); fast = 1'b0;
    chk("R4 stop ends on fast tick", {busy, done, idx}, {1'b0, 1'b1, AW'(0)});
  endtask

  task automatic t_wrap();
    int n = 0;
    for (int i = 1; i < DEPTH; i++) wr(i, mk(0,0,0, 0,0,0,0,0,0,0, i));
    fast = 1'b1;
    pulse_start();
    while (busy && n < 100) begin n++; @(negedge clk); end
    chk("R10 states before wrap", n, DEPTH - 1);
    chk("R10 wrap error pulse", {err, done, idx}, {1'b1, 1'b0, AW'(0)});
    @(negedge clk);
    chk("R10 error single cycle", err, 0);
  endtask

  initial begin
    #200_000;
    miscompares++;
    $display("FAIL watchdog: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #23 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bus_idle();
    t_fast_seq();
    t_slow_seq();
    t_wrap();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule